// File: doc/BRIEF.md
# Floating-Point Issue Latency Scheduler

This block sits beside a single-precision floating-point pipeline and decides when each request may start and when its result is due. There are two execution resources. The multiply resource overlaps its work: a new product may begin every six cycles, and each one needs eight cycles to complete. A second resource is not pipelined and handles all other work: add, subtract, compare, both conversions, divide, square root, and the short moves, sign operations, loads and stores. No arithmetic is computed here. The block only models timing, structural hazards and the trap for work it cannot perform.

A requester holds a request (opcode, precision flag, destination tag) with `req_valid` until `req_ready` is high on a rising edge. Each accepted request leads to exactly one of two outcomes. A legal single-precision request produces one `done_valid` pulse that carries its tag after the fixed latency of its opcode. A double-precision or undefined request produces one `trap_pulse` that carries its tag, and is never executed. At most one completion is reported per cycle. When both resources finish in the same cycle, the product is reported first.

Top module: `fpis_sched`

## Requirements
- R1: After reset `req_ready` is high for any request and `done_valid` and `trap_pulse` are low.
- R2: A multiply (opcode 2) accepted on edge A gives `done_valid` with its tag after edge A+8. The next multiply is not accepted before edge A+6 and, if held waiting, is accepted on edge A+6.
- R3: Latencies on the shared resource are: add 0 and subtract 1 take 4, compare 5 takes 3, divide 3 takes 32, square root 4 takes 31, float-to-fixed 6 takes 4, fixed-to-float 7 takes 6, abs 8, move 9 and negate 10 take 1, load 11 takes 2, and store 12 takes 1.
- R4: The shared resource is not pipelined. A shared request that waits behind an operation accepted on edge S with latency L is accepted on edge S+L, which is the edge on which that result becomes due.
- R5: A multiply may be accepted while a shared operation is in flight, and a shared operation may be accepted while a multiply is in flight.
- R6: If a multiply and a shared operation are due on the same edge, the multiply is reported on that edge and the shared result one edge later. The shared resource accepts nothing on the clashing edge.
- R7: A request with `req_dbl` high is accepted at once, gives `trap_pulse` with its tag after the accepting edge, and never produces `done_valid`.
- R8: Opcodes 13 to 15 are undefined. They are treated like R7: accepted at once, trapped with their tag, and never completed.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both high. Trap requests see `req_ready` high whatever the resources are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Opcode, encoding as in R2, R3 and R8 |
| req_dbl | input | 1 | Request uses double precision or a double register |
| req_tag | input | TAG_W | Destination register tag |
| req_ready | output | 1 | Request taken on this edge if valid |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_tag | output | TAG_W | Tag of the trapped request |
| done_valid | output | 1 | One-cycle completion indication |
| done_tag | output | TAG_W | Tag of the completed request |

## Verification
Two functions can land on the same edge: the multiply resource finishing a product and the shared resource finishing its operation. The bench provokes this by accepting an add four cycles after a multiply, so that both are due eight cycles after the multiply. The scoreboard then expects the product on that edge and the sum one edge later. It also holds a second add behind the clash and requires that add to be accepted only on the deferred edge. In every other test the bench predicts completion edges with the same rule, so it also catches a clash that should not be deferred.

// File: rtl/fpis_pkg.sv
package fpis_pkg;

    localparam int OP_W  = 4;
    localparam int LAT_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MUL   = 4'd2,
        OP_DIV   = 4'd3,
        OP_SQRT  = 4'd4,
        OP_CMP   = 4'd5,
        OP_F2I   = 4'd6,
        OP_I2F   = 4'd7,
        OP_ABS   = 4'd8,
        OP_MOV   = 4'd9,
        OP_NEG   = 4'd10,
        OP_LOAD  = 4'd11,
        OP_STORE = 4'd12
    } fp_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd12;

    // Fixed latency of each shared-resource opcode (R3)
    function automatic logic [LAT_W-1:0] shared_lat(input logic [OP_W-1:0] op);
        logic [LAT_W-1:0] lat;
        case (op)
            OP_ADD, OP_SUB, OP_F2I: lat = 6'd4;
            OP_CMP:                 lat = 6'd3;
            OP_DIV:                 lat = 6'd32;
            OP_SQRT:                lat = 6'd31;
            OP_I2F:                 lat = 6'd6;
            OP_LOAD:                lat = 6'd2;
            default:                lat = 6'd1;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/fpis_decode.sv
module fpis_decode
    import fpis_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic             dbl_i,
    output logic             is_mul_o,
    output logic             trap_o,
    output logic [LAT_W-1:0] lat_o
);
    always_comb begin
        // double precision or an undefined code both trap (R7, R8)
        trap_o   = dbl_i || (op_i > OP_LAST);
        is_mul_o = !trap_o && (op_i == OP_MUL);
        lat_o    = shared_lat(op_i);
    end
endmodule

// File: rtl/fpis_mul_unit.sv
module fpis_mul_unit #(
    parameter int TAG_W = 5,
    parameter int LAT   = 8,
    parameter int II    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] issue_tag_i,
    output logic             can_issue_o,
    output logic             fin_o,
    output logic [TAG_W-1:0] fin_tag_o
);
    localparam int SLOTS = (LAT + II - 1) / II;
    localparam int CW    = $clog2(LAT + 1);
    localparam int GW    = $clog2(II + 1);
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [SLOTS-1:0][CW-1:0]    cnt;
        logic [SLOTS-1:0][TAG_W-1:0] tag;
        logic [GW-1:0]               gap;
    } mul_st_t;

    mul_st_t s_d, s_q;

    logic [SLOTS-1:0] slot_fin;
    logic [SLOTS-1:0] slot_open;
    logic             found;
    logic [SW-1:0]    sel;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign slot_fin[g]  = (s_q.cnt[g] == CW'(1));
            assign slot_open[g] = (s_q.cnt[g] <= CW'(1));
        end
    endgenerate

    // slot choice and issue permission depend on state only
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!found && slot_open[i]) begin
                found = 1'b1;
                sel   = SW'(i);
            end
        end
        can_issue_o = found && (s_q.gap <= GW'(1));
    end

    always_comb begin
        s_d       = s_q;
        fin_o     = |slot_fin;
        fin_tag_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_fin[i]) fin_tag_o = s_q.tag[i];
            if (s_q.cnt[i] != '0) s_d.cnt[i] = s_q.cnt[i] - CW'(1);
        end
        if (s_q.gap != '0) s_d.gap = s_q.gap - GW'(1);
        if (issue_i && can_issue_o) begin
            s_d.cnt[sel] = CW'(LAT);
            s_d.tag[sel] = issue_tag_i;
            s_d.gap      = GW'(II);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fpis_shared_unit.sv
module fpis_shared_unit
    import fpis_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] issue_tag_i,
    input  logic [LAT_W-1:0] issue_lat_i,
    input  logic             blocked_i,
    output logic             can_issue_o,
    output logic             fin_o,
    output logic [TAG_W-1:0] fin_tag_o
);
    typedef struct packed {
        logic [LAT_W-1:0] cnt;
        logic [TAG_W-1:0] tag;
        logic             hold;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic   ending;

    always_comb begin
        ending      = (s_q.cnt == LAT_W'(1));
        can_issue_o = (s_q.cnt == '0) || (ending && !blocked_i);
    end

    always_comb begin
        s_d       = s_q;
        fin_o     = s_q.hold || (ending && !blocked_i);
        fin_tag_o = s_q.tag;
        // a clash with the multiplier parks the result for one cycle
        s_d.hold  = ending && blocked_i;
        if (s_q.cnt != '0) s_d.cnt = s_q.cnt - LAT_W'(1);
        if (issue_i && can_issue_o) begin
            s_d.cnt = issue_lat_i;
            s_d.tag = issue_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fpis_sched.sv
module fpis_sched
    import fpis_pkg::*;
#(
    parameter int TAG_W   = 5,
    parameter int MUL_LAT = 8,
    parameter int MUL_II  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic             req_dbl,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic             trap_pulse,
    output logic [TAG_W-1:0] trap_tag,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag
);
    typedef struct packed {
        logic             done_v;
        logic [TAG_W-1:0] done_tag;
        logic             trap_v;
        logic [TAG_W-1:0] trap_tag;
    } out_st_t;

    out_st_t o_d, o_q;

    logic             is_mul, is_trap;
    logic [LAT_W-1:0] op_lat;
    logic             mul_can, mul_fin, mul_issue;
    logic [TAG_W-1:0] mul_tag;
    logic             sh_can, sh_fin, sh_issue;
    logic [TAG_W-1:0] sh_tag;

    fpis_decode u_dec (
        .op_i     (req_op),
        .dbl_i    (req_dbl),
        .is_mul_o (is_mul),
        .trap_o   (is_trap),
        .lat_o    (op_lat)
    );

    fpis_mul_unit #(.TAG_W(TAG_W), .LAT(MUL_LAT), .II(MUL_II)) u_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (mul_issue),
        .issue_tag_i (req_tag),
        .can_issue_o (mul_can),
        .fin_o       (mul_fin),
        .fin_tag_o   (mul_tag)
    );

    fpis_shared_unit #(.TAG_W(TAG_W)) u_sh (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (sh_issue),
        .issue_tag_i (req_tag),
        .issue_lat_i (op_lat),
        .blocked_i   (mul_fin),
        .can_issue_o (sh_can),
        .fin_o       (sh_fin),
        .fin_tag_o   (sh_tag)
    );

    always_comb begin
        req_ready = is_trap ? 1'b1 : (is_mul ? mul_can : sh_can);
        mul_issue = req_valid && is_mul && mul_can;
        sh_issue  = req_valid && !is_trap && !is_mul && sh_can;
    end

    always_comb begin
        o_d.done_v   = mul_fin || sh_fin;
        o_d.done_tag = mul_fin ? mul_tag : (sh_fin ? sh_tag : '0);
        o_d.trap_v   = req_valid && is_trap;
        o_d.trap_tag = (req_valid && is_trap) ? req_tag : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign done_valid = o_q.done_v;
    assign done_tag   = o_q.done_tag;
    assign trap_pulse = o_q.trap_v;
    assign trap_tag   = o_q.trap_tag;
endmodule

// File: rtl/fpis_sched_chk.sv
module fpis_sched_chk
    import fpis_pkg::*;
#(
    parameter int MUL_II = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_op,
    input logic       req_dbl,
    input logic       req_ready,
    input logic       trap_pulse
);
    localparam int SW = $clog2(MUL_II + 1);

    logic          mul_acc;
    logic          bad_req;
    logic [SW-1:0] since_q;

    assign mul_acc = req_valid && req_ready && !req_dbl && (req_op == OP_MUL);
    assign bad_req = req_dbl || (req_op > OP_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)                    since_q <= SW'(MUL_II);
        else if (mul_acc)              since_q <= SW'(1);
        else if (since_q < SW'(MUL_II)) since_q <= since_q + SW'(1);
    end

    p_mul_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mul_acc |-> (since_q >= SW'(MUL_II)));

    p_trap_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_req) |-> req_ready);

    p_dbl_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dbl) |=> trap_pulse);

    p_badop_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dbl && (req_op > OP_LAST)) |=> trap_pulse);

    p_trap_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(req_valid && bad_req));
endmodule

bind fpis_sched fpis_sched_chk #(.MUL_II(MUL_II)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_dbl    (req_dbl),
    .req_ready  (req_ready),
    .trap_pulse (trap_pulse)
);

// File: tb/fpis_sched_tb.sv
`timescale 1ns/1ps
module fpis_sched_tb;
    localparam int TAG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_op = '0;
    logic             req_dbl = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_ready, trap_pulse, done_valid;
    logic [TAG_W-1:0] trap_tag, done_tag;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    int    exp_tag[$];
    int    exp_cyc[$];
    bit    exp_mul[$];
    string exp_req[$];
    int    mul_hist[$];
    int    trp_tag[$];
    int    trp_cyc[$];
    string trp_req[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpis_sched #(.TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_dbl(req_dbl), .req_tag(req_tag), .req_ready(req_ready),
        .trap_pulse(trap_pulse), .trap_tag(trap_tag),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    function automatic int blat(input int op);
        case (op)
            0, 1, 6: return 4;
            2:       return 8;
            3:       return 32;
            4:       return 31;
            5:       return 3;
            7:       return 6;
            11:      return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    function automatic bit mul_due(input int c);
        foreach (mul_hist[i]) if (mul_hist[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    // driver: holds the request until taken, pushes expectations
    task automatic issue(input int op, input bit dbl, input int tag,
                         input string rq, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'(op); req_dbl = dbl; req_tag = TAG_W'(tag);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        if (dbl || op > 12) begin
            trp_tag.push_back(tag); trp_cyc.push_back(acc); trp_req.push_back(rq);
        end else begin
            exp_tag.push_back(tag); exp_cyc.push_back(acc + blat(op));
            exp_mul.push_back(op == 2); exp_req.push_back(rq);
            if (op == 2) mul_hist.push_back(acc + blat(op));
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic idle_to(input int n);
        do @(negedge clk); while (cyc < n);
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_tag.size() != 0 || trp_tag.size() != 0) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(exp_tag.size() == 0 && trp_tag.size() == 0, "R2/R3",
              "outstanding items after drain", exp_tag.size() + trp_tag.size(), 0);
    endtask

    // monitor: pops and compares completions and traps
    always @(negedge clk) begin
        if (rst_n && done_valid) begin : mon_done
            int idx;
            int e;
            idx = -1;
            foreach (exp_tag[i]) if (idx < 0 && exp_tag[i] == int'(done_tag)) idx = i;
            if (idx < 0) begin
                check(1'b0, "R7", "unexpected done tag", int'(done_tag), -1);
            end else begin
                e = exp_cyc[idx];
                if (!exp_mul[idx] && mul_due(e)) e = e + 1; // R6 deferral
                check(cyc == e, exp_req[idx], "done cycle", cyc, e);
                exp_tag.delete(idx); exp_cyc.delete(idx);
                exp_mul.delete(idx); exp_req.delete(idx);
            end
        end
        if (rst_n && trap_pulse) begin
            if (trp_tag.size() == 0) begin
                check(1'b0, "R7", "unexpected trap", int'(trap_tag), -1);
            end else begin
                check(cyc == trp_cyc[0], trp_req[0], "trap cycle", cyc, trp_cyc[0]);
                check(int'(trap_tag) == trp_tag[0], trp_req[0], "trap tag",
                      int'(trap_tag), trp_tag[0]);
                void'(trp_tag.pop_front()); void'(trp_cyc.pop_front());
                void'(trp_req.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int a1, a2, m, t4, t5, d, am, at, ad, ab;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(done_valid == 1'b0, "R1", "done after reset", done_valid, 0);
        check(trap_pulse == 1'b0, "R1", "trap after reset", trap_pulse, 0);

        // R3: every legal opcode once, completions predicted per opcode
        for (int op = 0; op <= 12; op++) begin
            issue(op, 1'b0, op, (op == 2) ? "R2" : "R3", a1);
        end
        drain();

        // R2: two multiplies back to back, second held until edge A+6
        issue(2, 1'b0, 1, "R2", a1);
        issue(2, 1'b0, 2, "R2", a2);
        check(a2 - a1 == 6, "R2", "multiply issue spacing", a2 - a1, 6);
        drain();

        // R5/R6: add due on the same edge as a multiply
        issue(2, 1'b0, 3, "R2", m);
        idle_to(m + 2);
        issue(0, 1'b0, 4, "R6", t4);
        check(t4 == m + 4, "R5", "shared accept during multiply", t4, m + 4);
        issue(1, 1'b0, 5, "R6", t5);
        check(t5 == m + 9, "R6", "shared accept after clash", t5, m + 9);
        drain();

        // R4/R5/R7/R9: divide busy, multiply and trap pass, add waits
        issue(3, 1'b0, 6, "R4", d);
        issue(2, 1'b0, 8, "R5", am);
        check(am == d + 1, "R5", "multiply accept during divide", am, d + 1);
        issue(0, 1'b1, 9, "R7", at);
        check(at == am + 1, "R9", "trap request not stalled", at, am + 1);
        issue(0, 1'b0, 7, "R4", ad);
        check(ad == d + 32, "R4", "add held behind divide", ad, d + 32);
        drain();

        // R8: undefined opcodes trap; a double multiply also traps
        issue(14, 1'b0, 10, "R8", ab);
        issue(15, 1'b0, 11, "R8", ab);
        issue(2, 1'b1, 12, "R7", ab);
        issue(13, 1'b0, 13, "R8", ab);
        drain();
        repeat (10) @(negedge clk);
        check(exp_tag.size() == 0, "R7", "no completion for trapped work",
              exp_tag.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule